// File: doc/BRIEF.md
# Trap Return State Sequencer

This block performs the architectural state change that a processor core needs when it leaves a trap handler through either the machine-level return or the supervisor-level return. The core presents the current privilege level, the virtualization mode, the relevant machine and hypervisor status bits, and both saved exception PCs. It also says whether compressed instructions and the hypervisor extension are implemented. It then pulses a request that names the return form.

The sequencer captures that context and runs the legality checks in a fixed priority. It then either commits the updated interrupt-enable stack, previous-privilege fields, privilege level and virtualization mode in a single clock edge, or flags an exception with a cause code and leaves every field as it was. The return target is always presented, so the core can use it as the next fetch address or as the trap value.

The control path is a four-state machine:
- **IDLE** waits for a request.
- **EVAL** judges the captured context and writes the result registers.
- **DONE** shows a one-cycle commit strobe and then goes back to IDLE.
- **FAULT** shows a one-cycle exception strobe and then goes back to IDLE.

The transitions are IDLE→EVAL on a request, EVAL→DONE when every check passes, EVAL→FAULT when a check fails, and DONE/FAULT→IDLE unconditionally. A request that arrives outside IDLE is not taken.

Top module: `tret_seq`

## Requirements
- R1: After reset, `done_o` and `exc_o` are 0, `priv_o` is 3 (machine), `virt_o` is 0, every status output is 0 and `ret_pc_o` is 0.
- R2: A request sampled at a clock edge produces no strobe in the following cycle. In the cycle after that, exactly one of `done_o`/`exc_o` is high, and for one cycle only. Privilege encoding is 0 user, 1 supervisor, 3 machine.
- R3: The supervisor return with `priv_i` = 0, or the machine return with `priv_i` ≠ 3, raises an exception with cause 2.
- R4: With `has_c_i` = 0 and the selected saved PC having a nonzero value in bits [1:0], the return raises cause 0. With `has_c_i` = 1 those bits are not checked.
- R5: The supervisor return with `tsr_i` = 1 while `priv_i` ≠ 3 raises cause 2.
- R6: The supervisor return with `has_h_i` = 1, `virt_i` = 1 and `vtsr_i` = 1 raises cause 22.
- R7: When several checks fail, the reported cause follows this order: privilege (R3), alignment (R4), trap bit (R5), virtual trap bit (R6).
- R8: A successful machine return sets `mie_o` to the old MPIE, `mpie_o` to 1, `mpp_o` to 0 and `mpv_o` to 0, and sets `priv_o` to the old MPP.
- R9: On a successful machine return, `virt_o` takes the old MPV when `has_h_i` = 1 and otherwise keeps `virt_i`.
- R10: A successful supervisor return sets `sie_o` to the old SPIE, `spie_o` to 1 and `spp_o` to 0, and sets `priv_o` to {0, old SPP}.
- R11: On a successful supervisor return with `has_h_i` = 1 and `virt_i` = 0, `virt_o` takes `spv_i` and `spv_o` becomes 0. Otherwise both keep their input values.
- R12: Fields that a return does not name pass through unchanged. On an exception, every status, privilege and mode output equals its input.
- R13: `ret_pc_o` shows `mepc_i` for the machine return and `sepc_i` for the supervisor return, whether the return commits or faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle return request |
| req_sret_i | input | 1 | 1 = supervisor return, 0 = machine return |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Current virtualization mode |
| has_c_i | input | 1 | Compressed instructions implemented |
| has_h_i | input | 1 | Hypervisor extension implemented |
| tsr_i | input | 1 | Trap-supervisor-return status bit |
| vtsr_i | input | 1 | Hypervisor virtual trap-supervisor-return bit |
| mie_i | input | 1 | Machine interrupt enable |
| mpie_i | input | 1 | Machine previous interrupt enable |
| mpp_i | input | 2 | Machine previous privilege |
| mpv_i | input | 1 | Machine previous virtualization |
| sie_i | input | 1 | Supervisor interrupt enable |
| spie_i | input | 1 | Supervisor previous interrupt enable |
| spp_i | input | 1 | Supervisor previous privilege |
| spv_i | input | 1 | Hypervisor supervisor previous virtualization |
| mepc_i | input | XLEN | Machine saved exception PC |
| sepc_i | input | XLEN | Supervisor saved exception PC |
| done_o | output | 1 | Commit strobe |
| exc_o | output | 1 | Exception strobe |
| cause_o | output | CAUSE_W | Exception cause, valid with `exc_o` |
| priv_o | output | 2 | Resulting privilege level |
| virt_o | output | 1 | Resulting virtualization mode |
| mie_o | output | 1 | Resulting MIE |
| mpie_o | output | 1 | Resulting MPIE |
| mpp_o | output | 2 | Resulting MPP |
| mpv_o | output | 1 | Resulting MPV |
| sie_o | output | 1 | Resulting SIE |
| spie_o | output | 1 | Resulting SPIE |
| spp_o | output | 1 | Resulting SPP |
| spv_o | output | 1 | Resulting SPV |
| ret_pc_o | output | XLEN | Selected return target |

## Verification
The bench builds the block with its defaults: XLEN = 32 and CAUSE_W = 5. The 5-bit cause field is wide enough to show the virtual-instruction code 22 next to codes 0 and 2. Full 32-bit saved PCs with random low bits let the alignment check fire or stay quiet in both extension settings. These settings also let random contexts stack several failing checks on one request, which exercises the priority order alongside directed cases for each single failure.

// File: rtl/tret_pkg.sv
package tret_pkg;

    localparam logic [1:0] LVL_U = 2'd0;
    localparam logic [1:0] LVL_S = 2'd1;
    localparam logic [1:0] LVL_M = 2'd3;

    localparam int CAUSE_MISALIGN = 0;
    localparam int CAUSE_ILLEGAL  = 2;
    localparam int CAUSE_VINSN    = 22;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       mpv;
        logic       sie;
        logic       spie;
        logic       spp;
        logic       spv;
    } stat_t;

endpackage

// File: rtl/tret_check.sv
module tret_check
    import tret_pkg::*;
#(
    parameter int CAUSE_W = 5
) (
    input  logic               is_sret,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic               has_c,
    input  logic               has_h,
    input  logic               tsr,
    input  logic               vtsr,
    input  logic [1:0]         tgt_lo,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);

    localparam logic [CAUSE_W-1:0] C_ILL = CAUSE_W'(CAUSE_ILLEGAL);
    localparam logic [CAUSE_W-1:0] C_MIS = CAUSE_W'(CAUSE_MISALIGN);
    localparam logic [CAUSE_W-1:0] C_VI  = CAUSE_W'(CAUSE_VINSN);

    logic priv_bad;
    logic misal;
    logic tsr_bad;
    logic vtsr_bad;

    always_comb begin
        priv_bad = is_sret ? (priv < LVL_S) : (priv != LVL_M);
        misal    = !has_c && (tgt_lo != 2'b00);
        tsr_bad  = is_sret && tsr && (priv != LVL_M);
        vtsr_bad = is_sret && has_h && virt && vtsr;
        fault    = priv_bad || misal || tsr_bad || vtsr_bad;
        // priority: privilege, alignment, trap bit, virtual trap bit
        if (priv_bad)      cause = C_ILL;
        else if (misal)    cause = C_MIS;
        else if (tsr_bad)  cause = C_ILL;
        else if (vtsr_bad) cause = C_VI;
        else               cause = '0;
    end

endmodule

// File: rtl/tret_update.sv
module tret_update
    import tret_pkg::*;
(
    input  logic       is_sret,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       has_h,
    input  stat_t      st,
    output stat_t      nst,
    output logic [1:0] npriv,
    output logic       nvirt
);

    always_comb begin
        nst   = st;
        npriv = priv;
        nvirt = virt;
        if (!is_sret) begin
            npriv    = st.mpp;
            nst.mie  = st.mpie;
            nst.mpie = 1'b1;
            nst.mpp  = LVL_U;
            nst.mpv  = 1'b0;
            if (has_h) begin
                nvirt = st.mpv;
            end
        end else begin
            npriv    = {1'b0, st.spp};
            nst.sie  = st.spie;
            nst.spie = 1'b1;
            nst.spp  = 1'b0;
            if (has_h && !virt) begin
                nvirt   = st.spv;
                nst.spv = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tret_seq.sv
module tret_seq
    import tret_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               req_sret_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic               has_c_i,
    input  logic               has_h_i,
    input  logic               tsr_i,
    input  logic               vtsr_i,
    input  logic               mie_i,
    input  logic               mpie_i,
    input  logic [1:0]         mpp_i,
    input  logic               mpv_i,
    input  logic               sie_i,
    input  logic               spie_i,
    input  logic               spp_i,
    input  logic               spv_i,
    input  logic [XLEN-1:0]    mepc_i,
    input  logic [XLEN-1:0]    sepc_i,
    output logic               done_o,
    output logic               exc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [1:0]         priv_o,
    output logic               virt_o,
    output logic               mie_o,
    output logic               mpie_o,
    output logic [1:0]         mpp_o,
    output logic               mpv_o,
    output logic               sie_o,
    output logic               spie_o,
    output logic               spp_o,
    output logic               spv_o,
    output logic [XLEN-1:0]    ret_pc_o
);

    seq_state_e state_q, state_d;

    // captured context
    logic            sret_q;
    logic [1:0]      priv_q;
    logic            virt_q;
    logic            hasc_q;
    logic            hash_q;
    logic            tsr_q;
    logic            vtsr_q;
    stat_t           st_q;
    logic [XLEN-1:0] tgt_q;

    // result registers
    stat_t              ost_q;
    logic [1:0]         opriv_q;
    logic               ovirt_q;
    logic [CAUSE_W-1:0] ocause_q;
    logic [XLEN-1:0]    opc_q;

    logic               chk_fault;
    logic [CAUSE_W-1:0] chk_cause;
    stat_t              upd_st;
    logic [1:0]         upd_priv;
    logic               upd_virt;

    tret_check #(.CAUSE_W(CAUSE_W)) u_check (
        .is_sret (sret_q),
        .priv    (priv_q),
        .virt    (virt_q),
        .has_c   (hasc_q),
        .has_h   (hash_q),
        .tsr     (tsr_q),
        .vtsr    (vtsr_q),
        .tgt_lo  (tgt_q[1:0]),
        .fault   (chk_fault),
        .cause   (chk_cause)
    );

    tret_update u_update (
        .is_sret (sret_q),
        .priv    (priv_q),
        .virt    (virt_q),
        .has_h   (hash_q),
        .st      (st_q),
        .nst     (upd_st),
        .npriv   (upd_priv),
        .nvirt   (upd_virt)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = ST_EVAL;
            ST_EVAL:  state_d = chk_fault ? ST_FAULT : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // context capture on an accepted request
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sret_q <= 1'b0;
            priv_q <= LVL_M;
            virt_q <= 1'b0;
            hasc_q <= 1'b0;
            hash_q <= 1'b0;
            tsr_q  <= 1'b0;
            vtsr_q <= 1'b0;
            st_q   <= '0;
            tgt_q  <= '0;
        end else if (state_q == ST_IDLE && req_i) begin
            sret_q <= req_sret_i;
            priv_q <= priv_i;
            virt_q <= virt_i;
            hasc_q <= has_c_i;
            hash_q <= has_h_i;
            tsr_q  <= tsr_i;
            vtsr_q <= vtsr_i;
            st_q   <= '{mie: mie_i, mpie: mpie_i, mpp: mpp_i, mpv: mpv_i,
                        sie: sie_i, spie: spie_i, spp: spp_i, spv: spv_i};
            tgt_q  <= req_sret_i ? sepc_i : mepc_i;
        end
    end

    // result commit: all fields in one edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ost_q    <= '0;
            opriv_q  <= LVL_M;
            ovirt_q  <= 1'b0;
            ocause_q <= '0;
            opc_q    <= '0;
        end else if (state_q == ST_EVAL) begin
            opc_q <= tgt_q;
            if (chk_fault) begin
                ost_q    <= st_q;
                opriv_q  <= priv_q;
                ovirt_q  <= virt_q;
                ocause_q <= chk_cause;
            end else begin
                ost_q    <= upd_st;
                opriv_q  <= upd_priv;
                ovirt_q  <= upd_virt;
            end
        end
    end

    // outputs
    always_comb begin
        done_o   = (state_q == ST_DONE);
        exc_o    = (state_q == ST_FAULT);
        cause_o  = ocause_q;
        priv_o   = opriv_q;
        virt_o   = ovirt_q;
        mie_o    = ost_q.mie;
        mpie_o   = ost_q.mpie;
        mpp_o    = ost_q.mpp;
        mpv_o    = ost_q.mpv;
        sie_o    = ost_q.sie;
        spie_o   = ost_q.spie;
        spp_o    = ost_q.spp;
        spv_o    = ost_q.spv;
        ret_pc_o = opc_q;
    end

endmodule

// File: rtl/tret_seq_chk.sv
module tret_seq_chk #(
    parameter int CAUSE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               exc,
    input logic [CAUSE_W-1:0] cause,
    input logic [1:0]         priv,
    input logic               virt,
    input logic               mpie,
    input logic [1:0]         mpp,
    input logic               mpv,
    input logic               spie,
    input logic               spp,
    input logic [1:0]         tgt_lo,
    input logic               snap_sret,
    input logic               snap_hasc,
    input logic [1:0]         snap_priv,
    input logic               snap_virt
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exc)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |=> !exc); // R2
    AST_SRET_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (done && snap_sret) |-> (snap_priv != 2'd0)); // R3
    AST_MRET_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !snap_sret) |-> (snap_priv == 2'd3)); // R3
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !snap_hasc) |-> (tgt_lo == 2'b00)); // R4
    AST_VTSR_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (exc && cause == CAUSE_W'(22)) |-> (snap_sret && snap_virt)); // R6
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (cause == CAUSE_W'(0) || cause == CAUSE_W'(2) || cause == CAUSE_W'(22))); // R7
    AST_MRET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !snap_sret) |-> (mpie && mpp == 2'd0 && !mpv)); // R8
    AST_SRET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && snap_sret) |-> (spie && !spp)); // R10
    AST_FAULT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (priv == snap_priv && virt == snap_virt)); // R12

endmodule

bind tret_seq tret_seq_chk #(.CAUSE_W(CAUSE_W)) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .done      (done_o),
    .exc       (exc_o),
    .cause     (cause_o),
    .priv      (priv_o),
    .virt      (virt_o),
    .mpie      (mpie_o),
    .mpp       (mpp_o),
    .mpv       (mpv_o),
    .spie      (spie_o),
    .spp       (spp_o),
    .tgt_lo    (ret_pc_o[1:0]),
    .snap_sret (sret_q),
    .snap_hasc (hasc_q),
    .snap_priv (priv_q),
    .snap_virt (virt_q)
);

// File: tb/sim_tret_seq.sv
`timescale 1ns/1ps
module sim_tret_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, req_sret_i = 1'b0;
    logic [1:0]  priv_i = 2'd3;
    logic        virt_i = 0, has_c_i = 1, has_h_i = 1, tsr_i = 0, vtsr_i = 0;
    logic        mie_i = 0, mpie_i = 0, mpv_i = 0, sie_i = 0, spie_i = 0, spp_i = 0, spv_i = 0;
    logic [1:0]  mpp_i = 2'd0;
    logic [31:0] mepc_i = 32'h100, sepc_i = 32'h200;

    logic        done_o, exc_o, virt_o, mie_o, mpie_o, mpv_o, sie_o, spie_o, spp_o, spv_o;
    logic [4:0]  cause_o;
    logic [1:0]  priv_o, mpp_o;
    logic [31:0] ret_pc_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tret_seq #(.XLEN(32), .CAUSE_W(5)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .req_sret_i(req_sret_i),
        .priv_i(priv_i), .virt_i(virt_i), .has_c_i(has_c_i), .has_h_i(has_h_i),
        .tsr_i(tsr_i), .vtsr_i(vtsr_i), .mie_i(mie_i), .mpie_i(mpie_i),
        .mpp_i(mpp_i), .mpv_i(mpv_i), .sie_i(sie_i), .spie_i(spie_i),
        .spp_i(spp_i), .spv_i(spv_i), .mepc_i(mepc_i), .sepc_i(sepc_i),
        .done_o(done_o), .exc_o(exc_o), .cause_o(cause_o), .priv_o(priv_o),
        .virt_o(virt_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
        .mpv_o(mpv_o), .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o),
        .spv_o(spv_o), .ret_pc_o(ret_pc_o)
    );

    task automatic check(input string rq, input logic [50:0] act, input logic [50:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [50:0] actual();
        return {done_o, exc_o, (exc_o ? cause_o : 5'd0), priv_o, virt_o, mie_o, mpie_o,
                mpp_o, mpv_o, sie_o, spie_o, spp_o, spv_o, ret_pc_o};
    endfunction

    // reference model built from the requirements
    function automatic logic [50:0] model(output string rq);
        logic flt = 1'b0;
        logic [4:0] c = 5'd0;
        logic [31:0] pc = req_sret_i ? sepc_i : mepc_i;
        logic [1:0] p = priv_i, a_mpp = mpp_i;
        logic v = virt_i, a_mie = mie_i, a_mpie = mpie_i, a_mpv = mpv_i;
        logic a_sie = sie_i, a_spie = spie_i, a_spp = spp_i, a_spv = spv_i;
        logic mis = !has_c_i && (pc[1:0] != 2'b00);
        rq = req_sret_i ? "R10" : "R8";
        if (req_sret_i) begin
            if (priv_i == 2'd0)                     begin flt = 1; c = 5'd2;  rq = "R3"; end
            else if (mis)                           begin flt = 1; c = 5'd0;  rq = "R4"; end
            else if (tsr_i && priv_i != 2'd3)       begin flt = 1; c = 5'd2;  rq = "R5"; end
            else if (has_h_i && virt_i && vtsr_i)   begin flt = 1; c = 5'd22; rq = "R6"; end
        end else begin
            if (priv_i != 2'd3)                     begin flt = 1; c = 5'd2;  rq = "R3"; end
            else if (mis)                           begin flt = 1; c = 5'd0;  rq = "R4"; end
        end
        if (!flt) begin
            if (!req_sret_i) begin
                p = mpp_i; a_mie = mpie_i; a_mpie = 1; a_mpp = 2'd0; a_mpv = 0;
                if (has_h_i) v = mpv_i;
            end else begin
                p = {1'b0, spp_i}; a_sie = spie_i; a_spie = 1; a_spp = 0;
                if (has_h_i && !virt_i) begin v = spv_i; a_spv = 0; end
            end
        end
        return {!flt, flt, c, p, v, a_mie, a_mpie, a_mpp, a_mpv, a_sie, a_spie, a_spp, a_spv, pc};
    endfunction

    task automatic run_op(input string tag);
        string rq;
        logic [50:0] e;
        e = model(rq);
        if (tag != "") rq = tag;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        check(rq, actual(), e);
        @(negedge clk);
    endtask

    task automatic defaults();
        req_sret_i = 0; priv_i = 2'd3; virt_i = 0; has_c_i = 1; has_h_i = 1;
        tsr_i = 0; vtsr_i = 0; mie_i = 0; mpie_i = 0; mpp_i = 2'd0; mpv_i = 0;
        sie_i = 0; spie_i = 0; spp_i = 0; spv_i = 0;
        mepc_i = 32'h0000_1000; sepc_i = 32'h0000_2000;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        defaults();
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", actual(), {2'b00, 5'd0, 2'd3, 1'b0, 9'd0, 32'd0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", actual(), {2'b00, 5'd0, 2'd3, 1'b0, 9'd0, 32'd0});

        // R2: strobe timing
        defaults(); mpie_i = 1; mpp_i = 2'd1;
        req_i = 1'b1; @(negedge clk); req_i = 1'b0;
        check("R2", {49'd0, done_o, exc_o}, 51'd0);
        @(negedge clk);
        check("R2", {49'd0, done_o, exc_o}, 51'd2);
        @(negedge clk);
        check("R2", {49'd0, done_o, exc_o}, 51'd0);

        // R8 / R9 machine return
        defaults(); mpie_i = 1; mpp_i = 2'd1; mpv_i = 1; run_op("R8");
        defaults(); has_h_i = 0; mpv_i = 1; mpp_i = 2'd0; run_op("R9");
        defaults(); has_h_i = 1; virt_i = 1; mpv_i = 0; run_op("R9");
        // R3 privilege checks
        defaults(); priv_i = 2'd1; run_op("R3");
        defaults(); req_sret_i = 1; priv_i = 2'd0; run_op("R3");
        // R4 alignment
        defaults(); has_c_i = 0; mepc_i = 32'h0000_1002; run_op("R4");
        defaults(); has_c_i = 1; mepc_i = 32'h0000_1002; run_op("R4");
        defaults(); req_sret_i = 1; priv_i = 2'd1; has_c_i = 0; sepc_i = 32'h0000_2001; run_op("R4");
        // R5 trap bit
        defaults(); req_sret_i = 1; priv_i = 2'd1; tsr_i = 1; run_op("R5");
        defaults(); req_sret_i = 1; priv_i = 2'd3; tsr_i = 1; spie_i = 1; run_op("R5");
        // R6 virtual trap bit
        defaults(); req_sret_i = 1; priv_i = 2'd1; virt_i = 1; vtsr_i = 1; run_op("R6");
        defaults(); req_sret_i = 1; priv_i = 2'd1; virt_i = 1; vtsr_i = 1; has_h_i = 0; run_op("R6");
        // R7 priority
        defaults(); req_sret_i = 1; priv_i = 2'd0; has_c_i = 0; sepc_i = 32'h3; tsr_i = 1; run_op("R7");
        defaults(); req_sret_i = 1; priv_i = 2'd1; has_c_i = 0; sepc_i = 32'h2; tsr_i = 1; run_op("R7");
        defaults(); req_sret_i = 1; priv_i = 2'd1; tsr_i = 1; virt_i = 1; vtsr_i = 1; run_op("R7");
        // R10 / R11 supervisor return
        defaults(); req_sret_i = 1; priv_i = 2'd1; spie_i = 1; spp_i = 1; run_op("R10");
        defaults(); req_sret_i = 1; priv_i = 2'd1; spv_i = 1; spp_i = 1; run_op("R11");
        defaults(); req_sret_i = 1; priv_i = 2'd1; virt_i = 1; spv_i = 1; run_op("R11");
        defaults(); req_sret_i = 1; priv_i = 2'd1; has_h_i = 0; spv_i = 1; run_op("R11");
        // R12 untouched fields and fault hold
        defaults(); sie_i = 1; spie_i = 0; spp_i = 1; spv_i = 1; mie_i = 1; run_op("R12");
        defaults(); req_sret_i = 1; priv_i = 2'd1; mie_i = 1; mpie_i = 1; mpp_i = 2'd3; mpv_i = 1; run_op("R12");
        defaults(); priv_i = 2'd0; mie_i = 1; mpp_i = 2'd3; sie_i = 1; virt_i = 1; run_op("R12");
        // R13 return target selection
        defaults(); mepc_i = 32'hDEAD_BEE0; sepc_i = 32'h1234_5670; run_op("R13");
        defaults(); req_sret_i = 1; priv_i = 2'd1; mepc_i = 32'hDEAD_BEE0; sepc_i = 32'h1234_5670; run_op("R13");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int pv;
            pv = $urandom % 3;
            req_sret_i = $urandom % 2;
            priv_i = (pv == 2) ? 2'd3 : 2'(pv);
            virt_i = $urandom % 2; has_c_i = $urandom % 2; has_h_i = $urandom % 2;
            tsr_i = ($urandom % 4) == 0; vtsr_i = ($urandom % 4) == 0;
            mie_i = $urandom % 2; mpie_i = $urandom % 2; mpp_i = 2'($urandom);
            mpv_i = $urandom % 2; sie_i = $urandom % 2; spie_i = $urandom % 2;
            spp_i = $urandom % 2; spv_i = $urandom % 2;
            mepc_i = $urandom; sepc_i = $urandom;
            if ($urandom % 2) begin mepc_i[1:0] = 2'b00; sepc_i[1:0] = 2'b00; end
            run_op("");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule